// File: doc/BRIEF.md
# Dual-Mode Countdown Counter/Timer

This block is a 16-bit down-counter fed from a reload register, with two modes. As an event counter, the host loads a reload value and issues a start strobe. The block then counts down once per selected clock tick and flags a ready status when the count reaches zero. It keeps counting through the wrap until the host issues a stop strobe. As a timer, it runs continuously and produces a square wave whose half-period is the reload value in source ticks. It raises ready on every second terminal count.

The tick source is either a crystal-derived enable or an external pin. The pin passes through a synchroniser and a rising-edge detector. Either source can optionally be divided by sixteen. The interrupt request is the ready status gated by an enable bit, and it stays asserted until a stop strobe clears the status. The count is read as two bytes with no snapshot latch, so software reads it only while the counter is halted.

Top module: `ct_dualmode`

## Requirements
- R1: After reset the count and reload value are 0, the control byte is 0 (counter mode, crystal source, divide by 1, interrupt disabled), `sq_out` is 1, and `ready` and `irq` are 0.
- R2: Host address 0 writes the reload low byte and reads the count low byte. Address 1 does the same for the high bytes. Address 2 writes and reads the control byte: bit 0 is the mode (1 = timer), bit 1 is the source (1 = pin), bit 2 is divide-by-16, and bit 3 is the interrupt enable.
- R3: In counter mode, a start strobe loads the reload value. Each tick after that lowers the count by one. The step from 1 to 0 sets `ready`, and the count then wraps from 0x0000 to 0xFFFF and keeps going.
- R4: In counter mode, a stop strobe halts the count and clears `ready`. A tick in the same cycle as the stop is not counted, and later ticks are ignored until the next start.
- R5: In counter mode, writing the reload register leaves the count unchanged. The new value is used at the next start.
- R6: In timer mode, a tick at count 1 reloads the count and inverts `sq_out`, and any other tick decrements. The square-wave period is therefore 2 × reload ticks.
- R7: In timer mode, `ready` is set only on the second, fourth, sixth (and so on) terminal count after a start.
- R8: In timer mode, a reload write has no immediate effect and is taken at the next automatic reload.
- R9: In timer mode, a stop strobe clears `ready` and the countdown keeps running.
- R10: In timer mode, a start strobe forces `sq_out` to 1, loads the reload value and restarts the terminal-count pairing.
- R11: With divide-by-16 selected, the count moves once per 16 source pulses. The divider restarts at every start strobe.
- R12: With the pin source selected, each rising edge of `pin_in` counts as one source pulse after a two-flop synchroniser, and crystal pulses are ignored.
- R13: `irq` equals `ready` AND the interrupt-enable bit, and it stays high until a stop clears `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational on address) |
| start_stb | input | 1 | Start command |
| stop_stb | input | 1 | Stop command |
| xtal_tick | input | 1 | Crystal-derived clock enable |
| pin_in | input | 1 | External asynchronous clock pin |
| sq_out | output | 1 | Square-wave output |
| ready | output | 1 | Ready status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit count from 8-bit bytes, a divide-by-16 prescaler and a two-stage pin synchroniser. With these values, small random reload values make the zero crossing, the wrap to 0xFFFF and several timer terminal-count pairs reachable in a few hundred ticks. The full 16-bit wrap stays exercised through reload values near zero. The divide-by-16 path and the synchroniser latency are short enough to check directly, using exact pulse counts around the prescaler boundary.

// File: rtl/ct_pkg.sv
package ct_pkg;
   typedef enum logic {
      CT_COUNTER = 1'b0,
      CT_TIMER   = 1'b1
   } ct_mode_e;

   // control byte layout, LSB first: mode, source, divide, interrupt enable
   typedef struct packed {
      logic     irq_en;
      logic     src_div16;
      logic     src_pin;
      ct_mode_e mode;
   } ct_ctrl_t;

   localparam int CT_CTRL_W = 4;
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ct_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], d_async};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;

   // R12
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic src,
   input  logic div_sel,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("ct_prescaler: DIV must be positive");
   end

   if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      logic          wrap;

      assign wrap = (pre_q == PW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (clr) begin
            pre_q <= '0;
         end else if (src && div_sel) begin
            pre_q <= wrap ? '0 : pre_q + PW'(1);
         end
      end

      assign tick = src && (!div_sel || wrap);
   end else begin : g_nodiv
      assign tick = src;
   end

   // R11
   tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> src);
endmodule

// File: rtl/ct_countdown.sv
module ct_countdown #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         start,
   input  logic         stop,
   input  logic         timer_mode,
   input  logic [W-1:0] preload,
   output logic [W-1:0] cnt,
   output logic         sq,
   output logic         ready
);
   if (W < 2) begin : g_bad_w
      $error("ct_countdown: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         sq_q, rdy_q, run_q, half_q;
   logic         advance, term, reload, rdy_set;

   always_comb begin
      advance = tick && !start && (timer_mode || (run_q && !stop));
      term    = (cnt_q == W'(1));
      reload  = advance && timer_mode && term;
      rdy_set = advance && term && (!timer_mode || half_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sq_q   <= 1'b1;
         half_q <= 1'b0;
         run_q  <= 1'b0;
      end else if (start) begin
         cnt_q  <= preload;
         sq_q   <= 1'b1;
         half_q <= 1'b0;
         run_q  <= 1'b1;
      end else begin
         if (stop && !timer_mode) run_q <= 1'b0;
         if (reload) begin
            cnt_q  <= preload;
            sq_q   <= ~sq_q;
            half_q <= ~half_q;
         end else if (advance) begin
            cnt_q <= cnt_q - W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdy_q <= 1'b0;
      else if (rdy_set) rdy_q <= 1'b1;
      else if (stop)    rdy_q <= 1'b0;
   end

   assign cnt   = cnt_q;
   assign sq    = sq_q;
   assign ready = rdy_q;

   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_mode && run_q && tick && !stop && !start && cnt_q == '0) |=> (cnt_q == '1));
   // R4
   stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start && !timer_mode) |=> $stable(cnt_q));
   // R9
   stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !tick) |=> !rdy_q);
   // R10
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (sq_q && cnt_q == $past(preload)));
   // R6
   term_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_mode && tick && !start && cnt_q == W'(1)) |=> (sq_q != $past(sq_q)));
endmodule

// File: rtl/ct_dualmode.sv
module ct_dualmode
   import ct_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int PRE_DIV     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic              start_stb,
   input  logic              stop_stb,
   input  logic              xtal_tick,
   input  logic              pin_in,
   output logic              sq_out,
   output logic              ready,
   output logic              irq
);
   localparam int CNT_W = 2 * BYTE_W;

   if (BYTE_W < CT_CTRL_W) begin : g_bad_byte
      $error("ct_dualmode: BYTE_W too narrow for control byte");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ct_dualmode: ADDR_W must be at least 2");
   end

   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

   logic [CNT_W-1:0] preload_q;
   ct_ctrl_t         ctrl_q;
   logic [CNT_W-1:0] cnt;
   logic             pin_rise, src, tick, rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload_q <= '0;
         ctrl_q    <= '0;
      end else if (host_wr) begin
         case (host_addr)
            A_LO:    preload_q[BYTE_W-1:0]     <= host_wdata;
            A_HI:    preload_q[CNT_W-1:BYTE_W] <= host_wdata;
            A_CTRL:  ctrl_q <= ct_ctrl_t'(host_wdata[CT_CTRL_W-1:0]);
            default: ;
         endcase
      end
   end

   always_comb begin
      case (host_addr)
         A_LO:    host_rdata = cnt[BYTE_W-1:0];
         A_HI:    host_rdata = cnt[CNT_W-1:BYTE_W];
         A_CTRL:  host_rdata = {{(BYTE_W-CT_CTRL_W){1'b0}}, ctrl_q};
         default: host_rdata = '0;
      endcase
   end

   ct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .rise    (pin_rise)
   );

   assign src = ctrl_q.src_pin ? pin_rise : xtal_tick;

   ct_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_stb),
      .src     (src),
      .div_sel (ctrl_q.src_div16),
      .tick    (tick)
   );

   ct_countdown #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start      (start_stb),
      .stop       (stop_stb),
      .timer_mode (ctrl_q.mode == CT_TIMER),
      .preload    (preload_q),
      .cnt        (cnt),
      .sq         (sq_out),
      .ready      (rdy)
   );

   assign ready = rdy;
   assign irq   = rdy & ctrl_q.irq_en;

   // R13
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ready);
endmodule

// File: tb/ct_dualmode_test.sv
module ct_dualmode_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       start_stb = 1'b0, stop_stb = 1'b0, xtal_tick = 1'b0, pin_in = 1'b0;
   logic       sq_out, ready, irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ct_dualmode uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .start_stb(start_stb),
      .stop_stb(stop_stb), .xtal_tick(xtal_tick), .pin_in(pin_in),
      .sq_out(sq_out), .ready(ready), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic set_preload(input int p);
      wr(2'd0, p[7:0]); wr(2'd1, p[15:8]);
   endtask

   task automatic do_start();
      @(negedge clk); start_stb = 1'b1;
      @(negedge clk); start_stb = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); stop_stb = 1'b1;
      @(negedge clk); stop_stb = 1'b0;
   endtask

   task automatic xt(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); xtal_tick = 1'b1;
         @(negedge clk); xtal_tick = 1'b0;
      end
   endtask

   task automatic pin(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pin_in = 1'b1;
         repeat (3) @(negedge clk);
         pin_in = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk); host_addr = a; #1; v = int'(host_rdata);
   endtask

   task automatic rd_cnt(output int v);
      int lo, hi;
      rd(2'd0, lo); rd(2'd1, hi);
      v = (hi << 8) | lo;
   endtask

   function automatic int f_cnt_count(input int p, input int n);
      return (p - n) & 16'hFFFF;
   endfunction
   function automatic int f_cnt_rdy(input int p, input int n);
      return (p != 0 && n >= p) ? 1 : 0;
   endfunction
   function automatic int f_tmr_cnt(input int p, input int n);
      return ((n % p) == 0) ? p : p - (n % p);
   endfunction
   function automatic int f_tmr_sq(input int p, input int n);
      return ((n / p) % 2 == 0) ? 1 : 0;
   endfunction
   function automatic int f_tmr_rdy(input int p, input int n);
      return (n / p >= 2) ? 1 : 0;
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v, p, n;
      v = int'($urandom(32'h5eed_c7a1));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_cnt(v);           chk("R1 count", v, 0);
      rd(2'd2, v);         chk("R1 ctrl", v, 0);
      chk("R1 sq", int'(sq_out), 1);
      chk("R1 ready", int'(ready), 0);
      chk("R1 irq", int'(irq), 0);

      // R2 control readback
      wr(2'd2, 8'h0A); rd(2'd2, v); chk("R2 ctrl", v, 8'h0A);
      wr(2'd2, 8'h00);

      // R3 counter mode, random reloads and tick counts
      for (int k = 0; k < 20; k++) begin
         p = int'($urandom_range(0, 40));
         n = int'($urandom_range(0, 50));
         do_stop(); set_preload(p); do_start(); xt(n);
         rd_cnt(v); chk("R3 count", v, f_cnt_count(p, n));
         chk("R3 ready", int'(ready), f_cnt_rdy(p, n));
      end
      // R3 wrap through zero
      do_stop(); set_preload(3); do_start(); xt(5);
      rd_cnt(v); chk("R3 wrap", v, 16'hFFFE);
      chk("R3 wrap ready", int'(ready), 1);

      // R4 stop halts and clears ready
      do_stop(); xt(4);
      rd_cnt(v); chk("R4 halted", v, 16'hFFFE);
      chk("R4 ready clr", int'(ready), 0);
      set_preload(10); do_start(); xt(2);
      @(negedge clk); stop_stb = 1'b1; xtal_tick = 1'b1;
      @(negedge clk); stop_stb = 1'b0; xtal_tick = 1'b0;
      rd_cnt(v); chk("R4 same-cycle tick", v, 8);

      // R5 reload write ignored until start
      set_preload(16'h1234);
      rd_cnt(v); chk("R5 no effect", v, 8);
      do_start();
      rd_cnt(v); chk("R5 start load", v, 16'h1234);

      // R13 interrupt gating and level
      do_stop(); wr(2'd2, 8'h08); set_preload(2); do_start(); xt(2);
      chk("R13 irq set", int'(irq), 1);
      xt(3);
      chk("R13 irq held", int'(irq), 1);
      do_stop();
      chk("R13 irq clr", int'(irq), 0);
      wr(2'd2, 8'h00); do_start(); xt(2);
      chk("R13 ready no irq", int'(ready), 1);
      chk("R13 irq masked", int'(irq), 0);
      do_stop();

      // R6 R7 timer mode, random
      wr(2'd2, 8'h01);
      for (int k = 0; k < 15; k++) begin
         p = int'($urandom_range(1, 12));
         n = int'($urandom_range(0, 60));
         do_stop(); set_preload(p); do_start(); xt(n);
         rd_cnt(v); chk("R6 timer count", v, f_tmr_cnt(p, n));
         chk("R6 sq", int'(sq_out), f_tmr_sq(p, n));
         chk("R7 ready pairing", int'(ready), f_tmr_rdy(p, n));
      end

      // R8 reload change taken at next automatic reload
      do_stop(); set_preload(4); do_start(); xt(2);
      set_preload(10);
      rd_cnt(v); chk("R8 no immediate", v, 2);
      xt(2);
      rd_cnt(v); chk("R8 reload new", v, 10);
      chk("R8 sq", int'(sq_out), 0);
      chk("R7 first term no ready", int'(ready), 0);
      xt(10);
      chk("R7 second term ready", int'(ready), 1);
      chk("R6 sq back", int'(sq_out), 1);

      // R9 stop clears ready, timer keeps running
      do_stop();
      chk("R9 ready clr", int'(ready), 0);
      xt(3);
      rd_cnt(v); chk("R9 still running", v, 7);

      // R10 start forces sq high and restarts pairing
      xt(7);
      chk("R10 sq low before", int'(sq_out), 0);
      do_start();
      chk("R10 sq forced", int'(sq_out), 1);
      rd_cnt(v); chk("R10 reload", v, 10);
      xt(10);
      chk("R10 pairing restart", int'(ready), 0);
      do_stop();

      // R11 divide by 16 and prescaler restart
      wr(2'd2, 8'h04); set_preload(5); do_start(); xt(15);
      rd_cnt(v); chk("R11 before 16th", v, 5);
      xt(1);
      rd_cnt(v); chk("R11 16th pulse", v, 4);
      do_start(); xt(10); do_start(); xt(10);
      rd_cnt(v); chk("R11 prescaler reset", v, 5);
      do_stop();

      // R12 pin source
      wr(2'd2, 8'h02); set_preload(100); do_start(); pin(7);
      rd_cnt(v); chk("R12 pin edges", v, 93);
      xt(5);
      rd_cnt(v); chk("R12 crystal ignored", v, 93);
      do_stop(); wr(2'd2, 8'h06); do_start(); pin(17);
      rd_cnt(v); chk("R12 pin div16", v, 99);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule